// File: doc/BRIEF.md
# Tagged Round-Robin Stream Merger

This block collects words from several independent valid/ready input streams and emits them on a single 32-bit output stream headed for a host. Each input port has its own small FIFO. Sources can therefore offer words in the same cycle, and none is stalled while another input owns the output. A round-robin arbiter chooses which non-empty FIFO supplies the next output word. Before the word leaves, its upper bits are overwritten with the index of the input it came from, so host software can sort the merged data back into per-source streams.

Every port carries only data, valid and ready. A word moves across a port on a rising clock edge where valid and ready are both high. The output side keeps an offered word steady until it is taken. Each input's ready signal shows that its FIFO has room. Reset is synchronous and active high.

Top module: `stream_merger_tagged`

## Requirements
- R1: While reset is high at a clock edge, the following cycle shows `m_tvalid` low and every bit of `s_tready` high.
- R2: Once `m_tvalid` is high, it stays high in each following cycle until a cycle in which `m_tready` is also high.
- R3: While `m_tvalid` is high and `m_tready` is low, `m_tdata` does not change in the next cycle.
- R4: Input ready `s_tready[i]` is low exactly when FIFO i holds FIFO_DEPTH words. A ready that is high stays high through any cycle in which `s_tvalid[i]` is low.
- R5: With the output stalled, one input accepts FIFO_DEPTH+1 words (one of them sits in the output register) before its ready drops. All of them later appear on the output, in arrival order, with none lost.
- R6: With N_IN=4, output bits [31:30] carry the input index (0 to 3) as an unsigned number. Bits [29:0] carry bits [29:0] of the accepted input word. Input bits [31:30] have no effect on the output.
- R7: After reset the search starts at input 0. After input i is granted, the next search starts at input i+1 and wraps from N_IN-1 to 0. With every input holding words, the output order is 0,1,2,3,0,1,...
- R8: Inputs with empty FIFOs are skipped. A grant goes only to an input whose FIFO holds a word.
- R9: With `m_tready` held high and words buffered, a new word is presented in every cycle.
- R10: A word accepted at an input on edge t, with the output register and all FIFOs empty, makes `m_tvalid` high just after edge t+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | N_IN*32 | Input words, input i in bits [32*i+31:32*i] |
| s_tvalid | input | N_IN | Per-input valid |
| s_tready | output | N_IN | Per-input ready (FIFO not full) |
| m_tdata | output | 32 | Tagged output word |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready from the host side |

## Verification
The assertions assume that each source obeys the input handshake. Once a source raises `s_tvalid` with a word, it holds that word until the cycle in which it is taken. The assertions make no assumption about `m_tready`, which may toggle freely. The stimulus drives inputs only at falling edges. It changes an input word only after the edge where that word was accepted, and it clears valid once the intended words have gone in. Backpressure is applied by holding `m_tready` low across whole stretches of cycles.

// File: rtl/stm_pkg.sv
package stm_pkg;
    // Width of every stream word, input and output.
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/stm_fifo.sv
module stm_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 30
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

    // R5: a word is never written into a full buffer
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R8: a word is never read from an empty buffer
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/stm_rr_arb.sv
module stm_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 take,
    output logic                 gnt_valid,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic             found;
    logic [IDX_W-1:0] pick;

    always_comb begin
        int c;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            c = int'(st_q.ptr) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
        st_d = st_q;
        if (take && found) begin
            st_d.ptr = (int'(pick) == N - 1) ? '0 : pick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gnt_valid = found;
    assign gnt_idx   = pick;

    // R8: grant only to an input that holds a word
    a_r8_grant_has_req: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_idx]);
    // R7: the pointer is consumed only with a live grant
    a_r7_take_needs_grant: assert property (@(posedge clk) disable iff (rst)
        take |-> gnt_valid);
endmodule

// File: rtl/stm_tag_out.sv
module stm_tag_out
    import stm_pkg::*;
#(
    parameter int TAG_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      avail,
    input  logic [TAG_W-1:0]          tag,
    input  logic [WORD_W-TAG_W-1:0]   payload,
    output logic                      take,
    output logic                      m_tvalid,
    output word_t                     m_tdata,
    input  logic                      m_tready
);
    typedef struct packed {
        logic  valid;
        word_t data;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = avail && (!st_q.valid || m_tready);
        if (take) begin
            st_d.valid = 1'b1;
            st_d.data  = {tag, payload};
        end else if (m_tready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign m_tvalid = st_q.valid;
    assign m_tdata  = st_q.data;
endmodule

// File: rtl/stream_merger_tagged.sv
module stream_merger_tagged
    import stm_pkg::*;
#(
    parameter int N_IN       = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_IN*WORD_W-1:0]   s_tdata,
    input  logic [N_IN-1:0]          s_tvalid,
    output logic [N_IN-1:0]          s_tready,
    output logic [WORD_W-1:0]        m_tdata,
    output logic                     m_tvalid,
    input  logic                     m_tready
);
    localparam int TAG_W = $clog2(N_IN);
    localparam int PAY_W = WORD_W - TAG_W;

    logic [N_IN-1:0]            push, pop, empty, full;
    logic [N_IN-1:0][PAY_W-1:0] heads;
    logic                       gnt_valid, take;
    logic [TAG_W-1:0]           gnt_idx;
    logic [PAY_W-1:0]           head_sel;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign s_tready[i] = !full[i];
        assign push[i]     = s_tvalid[i] && !full[i];
        assign pop[i]      = take && (gnt_idx == TAG_W'(i));

        stm_fifo #(.DEPTH(FIFO_DEPTH), .W(PAY_W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push[i]),
            .din   (s_tdata[i*WORD_W +: PAY_W]),
            .pop   (pop[i]),
            .dout  (heads[i]),
            .empty (empty[i]),
            .full  (full[i])
        );

        // R4: ready, once high, waits for a valid before it may drop
        a_r4_ready_hold: assert property (@(posedge clk) disable iff (rst)
            (s_tready[i] && !s_tvalid[i]) |=> s_tready[i]);
    end

    stm_rr_arb #(.N(N_IN)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (~empty),
        .take      (take),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    assign head_sel = heads[gnt_idx];

    stm_tag_out #(.TAG_W(TAG_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .avail    (gnt_valid),
        .tag      (gnt_idx),
        .payload  (head_sel),
        .take     (take),
        .m_tvalid (m_tvalid),
        .m_tdata  (m_tdata),
        .m_tready (m_tready)
    );

    // R1: reset leaves the output idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !m_tvalid);
    // R2: an offered word is not withdrawn
    a_r2_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> m_tvalid);
    // R3: an offered word is not altered while stalled
    a_r3_hold_data: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> $stable(m_tdata));
    // R9: a waiting grant is never left idle when the output frees up
    a_r9_no_bubble: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && m_tready) |=> m_tvalid);
endmodule

// File: tb/stream_merger_tagged_test.sv
module stream_merger_tagged_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N*32-1:0]   s_tdata = '0;
    logic [N-1:0]      s_tvalid = '0;
    logic [N-1:0]      s_tready;
    logic [31:0]       m_tdata;
    logic              m_tvalid;
    logic              m_tready = 1'b0;

    int tests  = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_merger_tagged #(.N_IN(N), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready)
    );

    // {source[65:64], input word[63:32], expected output[31:0]}
    localparam logic [65:0] VEC [8] = '{
        {2'd0, 32'h0000_0001, 32'h0000_0001},
        {2'd1, 32'h1234_5678, 32'h5234_5678},
        {2'd2, 32'hFFFF_1234, 32'hBFFF_1234},
        {2'd3, 32'hC000_0000, 32'hC000_0000},
        {2'd3, 32'h3FFF_FFFF, 32'hFFFF_FFFF},
        {2'd0, 32'hDEAD_BEEF, 32'h1EAD_BEEF},
        {2'd1, 32'h8000_0005, 32'h4000_0005},
        {2'd2, 32'h7FFF_FFFF, 32'hBFFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; s_tvalid = '0; m_tready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] rr_word(input int src, input int k);
        return 32'h00A0_0000 | (src << 8) | k;
    endfunction

    function automatic logic [31:0] rr_exp(input int src, input int k);
        return {src[1:0], rr_word(src, k)[29:0]};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        tests++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 m_tvalid", {31'd0, m_tvalid}, 32'd0);
        check("R1 s_tready", {28'd0, s_tready}, 32'h0000_000F);
        rst = 1'b0;
        m_tready = 1'b1;

        // Vector walk: tagging (R6) and latency (R10)
        for (int v = 0; v < 8; v++) begin
            int src;
            src = int'(VEC[v][65:64]);
            s_tdata[src*32 +: 32] = VEC[v][63:32];
            s_tvalid[src] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            s_tvalid[src] = 1'b0;
            check("R10 not early", {31'd0, m_tvalid}, 32'd0);
            @(posedge clk);
            @(negedge clk);
            check("R10 valid", {31'd0, m_tvalid}, 32'd1);
            check("R6 tagged word", m_tdata, VEC[v][31:0]);
            @(posedge clk);
            @(negedge clk);
        end
        check("R2 idle after drain", {31'd0, m_tvalid}, 32'd0);

        // Round-robin with all inputs loaded (R7, R9), stall stability (R2, R3)
        do_reset();
        for (int i = 0; i < N; i++) s_tdata[i*32 +: 32] = rr_word(i, 0);
        s_tvalid = '1;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) s_tdata[i*32 +: 32] = rr_word(i, 1);
        @(posedge clk);
        @(negedge clk);
        s_tvalid = '0;
        for (int c = 0; c < 3; c++) begin
            check("R2 held valid", {31'd0, m_tvalid}, 32'd1);
            check("R3 held data", m_tdata, rr_exp(0, 0));
            @(posedge clk);
            @(negedge clk);
        end
        m_tready = 1'b1;
        for (int j = 0; j < 8; j++) begin
            check("R9 back-to-back valid", {31'd0, m_tvalid}, 32'd1);
            check("R7 rr order", m_tdata, rr_exp(j % 4, j / 4));
            @(posedge clk);
            @(negedge clk);
        end
        check("R7 drained", {31'd0, m_tvalid}, 32'd0);

        // Buffer capacity and ordering on one input (R4, R5)
        do_reset();
        begin
            int acc;
            logic rdy;
            acc = 0;
            for (int c = 0; c < 8; c++) begin
                s_tvalid[1] = 1'b1;
                s_tdata[32 +: 32] = 32'h5000_0000 + acc;
                rdy = s_tready[1];
                @(posedge clk);
                if (rdy) acc++;
                @(negedge clk);
            end
            s_tvalid[1] = 1'b0;
            check("R5 words accepted", acc, 32'd5);
            check("R4 ready low when full", {31'd0, s_tready[1]}, 32'd0);
        end
        m_tready = 1'b1;
        for (int j = 0; j < 5; j++) begin
            check("R5 drain order", m_tdata, 32'h5000_0000 + j);
            @(posedge clk);
            @(negedge clk);
        end
        check("R4 ready back", {28'd0, s_tready}, 32'h0000_000F);

        // Skipping empty inputs (R8)
        do_reset();
        s_tdata[0 +: 32]  = 32'h0000_00A0;
        s_tdata[64 +: 32] = 32'h0000_00C0;
        s_tvalid = 4'b0101;
        @(posedge clk);
        @(negedge clk);
        s_tvalid = 4'b0001;
        s_tdata[0 +: 32]  = 32'h0000_00A1;
        @(posedge clk);
        @(negedge clk);
        s_tvalid = '0;
        m_tready = 1'b1;
        check("R8 first", m_tdata, 32'h0000_00A0);
        @(posedge clk);
        @(negedge clk);
        check("R8 skip to 2", m_tdata, 32'h8000_00C0);
        @(posedge clk);
        @(negedge clk);
        check("R8 wrap to 0", m_tdata, 32'h0000_00A1);
        @(posedge clk);
        @(negedge clk);
        check("R8 idle", {31'd0, m_tvalid}, 32'd0);

        finish_run();
    end
endmodule